// File: doc/BRIEF.md
# Reservation Station Scheduler

This block is the waiting room between the in-order allocation stage and the out-of-order execution units. Micro-ops arrive in groups of up to three per cycle. A group is accepted as a whole or not at all. Each accepted op takes one free entry, which holds its opcode, its destination tag, a port class and two source operands. Each operand has a tag, a data field and a ready bit. Two writeback buses broadcast result tags with data. Any waiting operand whose tag matches captures the data and becomes ready.

Every cycle, each of five dispatch ports is offered at most one op. That op is the oldest entry whose port class names the port and whose two operands are both ready. Age follows allocation order, and inside one group a lower slot counts as older. The entry is released in the cycle its dispatch handshake completes. A flush input empties the whole station in one cycle.

Both streams use valid/ready. On the allocation side, `alloc_ready` is high exactly when at least three entries are free. A group moves when `alloc_valid` and `alloc_ready` are both high, and the producer must hold it until then. On each dispatch port, `disp_valid` never depends on `disp_ready`. While the consumer withholds ready, the offer stays valid, although a younger offer can be replaced by an older op that has just become ready. A group that meets a flush in the same cycle is dropped.

Top module: `rs_sched`

## Requirements
- R1: The station holds 20 entries. `alloc_ready` is high exactly when at least three entries are free. When it is low, an offered group changes no state.
- R2: A dispatched op presents the opcode, the destination tag and both source data words it was allocated or woken with.
- R3: An entry is offered for dispatch only when both of its source ready bits are set.
- R4: A writeback on either bus whose tag matches a waiting operand stores that data and sets the ready bit. The entry can dispatch from the following cycle. A broadcast in the same cycle as allocation is also captured.
- R5: Each port offers at most one op per cycle, and only an op whose port class field (values 0 to 4) equals the port index. Different ports dispatch in the same cycle independently.
- R6: Among ready ops for one port, the one allocated earliest wins, and inside a group slot 0 is older than slot 1, which is older than slot 2.
- R7: An offered op stays offered while its port withholds ready. Its entry is freed in the cycle the handshake completes.
- R8: Flush empties all entries in one cycle. Afterwards no port offers anything, and later broadcasts wake nothing.
- R9: After reset the station is empty, `alloc_ready` is high and every `disp_valid` is low.
- R10: A group slot whose bit in `alloc_mask` is 0 allocates nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Clear every entry |
| alloc_valid | input | 1 | Allocation group offered |
| alloc_ready | output | 1 | At least three entries free |
| alloc_mask | input | 3 | Populated slots of the group |
| alloc_op | input | 3x8 | Opcode per slot |
| alloc_dst | input | 3x6 | Destination tag per slot |
| alloc_port | input | 3x3 | Port class per slot |
| alloc_s1_tag | input | 3x6 | First source tag per slot |
| alloc_s1_rdy | input | 3 | First source already valid |
| alloc_s1_data | input | 3x32 | First source data |
| alloc_s2_tag | input | 3x6 | Second source tag per slot |
| alloc_s2_rdy | input | 3 | Second source already valid |
| alloc_s2_data | input | 3x32 | Second source data |
| wb_valid | input | 2 | Writeback bus active |
| wb_tag | input | 2x6 | Writeback result tag |
| wb_data | input | 2x32 | Writeback result data |
| disp_valid | output | 5 | Op offered on each port |
| disp_ready | input | 5 | Port accepts its op |
| disp_op | output | 5x8 | Opcode per port |
| disp_dst | output | 5x6 | Destination tag per port |
| disp_s1_data | output | 5x32 | First operand per port |
| disp_s2_data | output | 5x32 | Second operand per port |

## Verification
The bench uses the default parameters: 20 entries, three allocation slots, two writeback buses and five ports. With these values it can fill 18 entries with ops that never become ready. That reaches the point where two free entries block a whole group, and one dispatch reopens allocation. Three slots with a gap in the mask show that a skipped slot allocates nothing. Five ports let all of them fire in one cycle, and two buses allow wakeup from each bus in turn.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_OP_W   = 8;
  localparam int RS_TAG_W  = 6;
  localparam int RS_DATA_W = 32;
  localparam int RS_PORT_W = 3;

  typedef struct packed {
    logic [RS_TAG_W-1:0]  tag;
    logic                 rdy;
    logic [RS_DATA_W-1:0] data;
  } rs_src_t;

  typedef struct packed {
    logic [RS_OP_W-1:0]   op;
    logic [RS_TAG_W-1:0]  dst;
    logic [RS_PORT_W-1:0] port;
    rs_src_t              s1;
    rs_src_t              s2;
  } rs_uop_t;
endpackage

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int ENTRIES = 20,
  parameter int PICKS   = 3,
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic [ENTRIES-1:0]            busy,
  output logic [PICKS-1:0][ENTRIES-1:0] pick_oh,
  output logic [CNT_W-1:0]              free_cnt
);
  logic [ENTRIES-1:0] taken;
  logic               hit;

  // lowest free entries go to the lowest slots
  always_comb begin
    taken    = busy;
    pick_oh  = '0;
    free_cnt = '0;
    hit      = 1'b0;
    for (int i = 0; i < ENTRIES; i++)
      free_cnt = free_cnt + CNT_W'(!busy[i]);
    for (int k = 0; k < PICKS; k++) begin
      hit = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        if (!taken[i] && !hit) begin
          pick_oh[k][i] = 1'b1;
          taken[i]      = 1'b1;
          hit           = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int ENTRIES = 20,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ENTRIES-1:0]              req,
  input  logic [ENTRIES-1:0][ENTRIES-1:0] older,   // older[j][i]: j allocated before i
  output logic [ENTRIES-1:0]              grant,
  output logic                            any,
  output logic [IDX_W-1:0]                idx
);
  logic blocked;

  always_comb begin
    grant   = '0;
    idx     = '0;
    blocked = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      blocked = 1'b0;
      for (int j = 0; j < ENTRIES; j++)
        if (req[j] && older[j][i]) blocked = 1'b1;
      grant[i] = req[i] && !blocked;
      if (grant[i]) idx = IDX_W'(i);
    end
    any = |grant;
  end

  // R5: a port offers one op at most
  assert_one_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R5: grant only to a requester
  assert_grant_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  // R6: the age order always leaves one oldest requester
  assert_oldest_exists_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> any);
endmodule

// File: rtl/rs_sched.sv
module rs_sched
  import rs_pkg::*;
#(
  parameter int ENTRIES = 20,
  parameter int ALLOC_W = 3,
  parameter int WB_N    = 2,
  parameter int NPORTS  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          alloc_valid,
  output logic                          alloc_ready,
  input  logic [ALLOC_W-1:0]            alloc_mask,
  input  logic [ALLOC_W*RS_OP_W-1:0]    alloc_op,
  input  logic [ALLOC_W*RS_TAG_W-1:0]   alloc_dst,
  input  logic [ALLOC_W*RS_PORT_W-1:0]  alloc_port,
  input  logic [ALLOC_W*RS_TAG_W-1:0]   alloc_s1_tag,
  input  logic [ALLOC_W-1:0]            alloc_s1_rdy,
  input  logic [ALLOC_W*RS_DATA_W-1:0]  alloc_s1_data,
  input  logic [ALLOC_W*RS_TAG_W-1:0]   alloc_s2_tag,
  input  logic [ALLOC_W-1:0]            alloc_s2_rdy,
  input  logic [ALLOC_W*RS_DATA_W-1:0]  alloc_s2_data,
  input  logic [WB_N-1:0]               wb_valid,
  input  logic [WB_N*RS_TAG_W-1:0]      wb_tag,
  input  logic [WB_N*RS_DATA_W-1:0]     wb_data,
  output logic [NPORTS-1:0]             disp_valid,
  input  logic [NPORTS-1:0]             disp_ready,
  output logic [NPORTS*RS_OP_W-1:0]     disp_op,
  output logic [NPORTS*RS_TAG_W-1:0]    disp_dst,
  output logic [NPORTS*RS_DATA_W-1:0]   disp_s1_data,
  output logic [NPORTS*RS_DATA_W-1:0]   disp_s2_data
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic [ENTRIES-1:0]              busy_q;
  rs_uop_t                         ent_q [ENTRIES];
  logic [ENTRIES-1:0][ENTRIES-1:0] older_q;

  logic [ALLOC_W-1:0][ENTRIES-1:0] pick_oh;
  logic [CNT_W-1:0]                free_cnt;
  logic                            alloc_fire;
  rs_uop_t                         in_uop [ALLOC_W];
  logic [ALLOC_W-1:0][ENTRIES-1:0] ahead, behind;

  logic [NPORTS-1:0][ENTRIES-1:0]  req, grant;
  logic [NPORTS-1:0][IDX_W-1:0]    sel_idx;
  logic [ENTRIES-1:0]              clr;

  rs_free_pick #(.ENTRIES(ENTRIES), .PICKS(ALLOC_W), .CNT_W(CNT_W)) u_pick (
    .busy(busy_q), .pick_oh(pick_oh), .free_cnt(free_cnt));

  assign alloc_ready = (free_cnt >= CNT_W'(ALLOC_W));
  assign alloc_fire  = alloc_valid && alloc_ready && !flush;

  // incoming ops, with same-cycle writeback capture
  always_comb begin
    for (int s = 0; s < ALLOC_W; s++) begin
      in_uop[s].op      = alloc_op[s*RS_OP_W +: RS_OP_W];
      in_uop[s].dst     = alloc_dst[s*RS_TAG_W +: RS_TAG_W];
      in_uop[s].port    = alloc_port[s*RS_PORT_W +: RS_PORT_W];
      in_uop[s].s1.tag  = alloc_s1_tag[s*RS_TAG_W +: RS_TAG_W];
      in_uop[s].s1.rdy  = alloc_s1_rdy[s];
      in_uop[s].s1.data = alloc_s1_data[s*RS_DATA_W +: RS_DATA_W];
      in_uop[s].s2.tag  = alloc_s2_tag[s*RS_TAG_W +: RS_TAG_W];
      in_uop[s].s2.rdy  = alloc_s2_rdy[s];
      in_uop[s].s2.data = alloc_s2_data[s*RS_DATA_W +: RS_DATA_W];
      for (int b = 0; b < WB_N; b++) begin
        if (!alloc_s1_rdy[s] && wb_valid[b] &&
            wb_tag[b*RS_TAG_W +: RS_TAG_W] == in_uop[s].s1.tag) begin
          in_uop[s].s1.rdy  = 1'b1;
          in_uop[s].s1.data = wb_data[b*RS_DATA_W +: RS_DATA_W];
        end
        if (!alloc_s2_rdy[s] && wb_valid[b] &&
            wb_tag[b*RS_TAG_W +: RS_TAG_W] == in_uop[s].s2.tag) begin
          in_uop[s].s2.rdy  = 1'b1;
          in_uop[s].s2.data = wb_data[b*RS_DATA_W +: RS_DATA_W];
        end
      end
    end
  end

  // entries taken by lower / higher populated slots of this group
  always_comb begin
    for (int s = 0; s < ALLOC_W; s++) begin
      ahead[s]  = '0;
      behind[s] = '0;
      for (int t = 0; t < ALLOC_W; t++) begin
        if (t < s && alloc_mask[t]) ahead[s]  = ahead[s]  | pick_oh[t];
        if (t > s && alloc_mask[t]) behind[s] = behind[s] | pick_oh[t];
      end
    end
  end

  // per-port oldest-ready selection
  genvar p;
  generate
    for (p = 0; p < NPORTS; p++) begin : g_port
      always_comb begin
        for (int i = 0; i < ENTRIES; i++)
          req[p][i] = busy_q[i] && ent_q[i].s1.rdy && ent_q[i].s2.rdy &&
                      (ent_q[i].port == RS_PORT_W'(p));
      end

      rs_select #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sel (
        .clk(clk), .rst_n(rst_n), .req(req[p]), .older(older_q),
        .grant(grant[p]), .any(disp_valid[p]), .idx(sel_idx[p]));

      assign disp_op[p*RS_OP_W +: RS_OP_W]          = ent_q[sel_idx[p]].op;
      assign disp_dst[p*RS_TAG_W +: RS_TAG_W]       = ent_q[sel_idx[p]].dst;
      assign disp_s1_data[p*RS_DATA_W +: RS_DATA_W] = ent_q[sel_idx[p]].s1.data;
      assign disp_s2_data[p*RS_DATA_W +: RS_DATA_W] = ent_q[sel_idx[p]].s2.data;

      // R3: offered op has both operands
      assert_srcs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[p] |-> (ent_q[sel_idx[p]].s1.rdy && ent_q[sel_idx[p]].s2.rdy));

      // R5: offered op belongs to this port
      assert_port_class_R5: assert property (@(posedge clk) disable iff (!rst_n)
        disp_valid[p] |-> (ent_q[sel_idx[p]].port == RS_PORT_W'(p)));

      // R7: offer held under back-pressure
      assert_offer_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[p] && !disp_ready[p] && !flush) |=> disp_valid[p]);

      // R7: handshake frees the entry
      assert_entry_freed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid[p] && disp_ready[p]) |=> !busy_q[$past(sel_idx[p])]);
    end
  endgenerate

  always_comb begin
    clr = '0;
    for (int q = 0; q < NPORTS; q++)
      if (disp_valid[q] && disp_ready[q]) clr = clr | grant[q];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= '0;
      older_q <= '0;
      for (int i = 0; i < ENTRIES; i++) ent_q[i] <= '0;
    end else if (flush) begin
      busy_q <= '0;
    end else begin
      // wakeup from the writeback buses
      for (int i = 0; i < ENTRIES; i++) begin
        for (int b = 0; b < WB_N; b++) begin
          if (busy_q[i] && !ent_q[i].s1.rdy && wb_valid[b] &&
              wb_tag[b*RS_TAG_W +: RS_TAG_W] == ent_q[i].s1.tag) begin
            ent_q[i].s1.rdy  <= 1'b1;
            ent_q[i].s1.data <= wb_data[b*RS_DATA_W +: RS_DATA_W];
          end
          if (busy_q[i] && !ent_q[i].s2.rdy && wb_valid[b] &&
              wb_tag[b*RS_TAG_W +: RS_TAG_W] == ent_q[i].s2.tag) begin
            ent_q[i].s2.rdy  <= 1'b1;
            ent_q[i].s2.data <= wb_data[b*RS_DATA_W +: RS_DATA_W];
          end
        end
        if (clr[i]) busy_q[i] <= 1'b0;
      end
      // allocation, age matrix row and column update
      for (int s = 0; s < ALLOC_W; s++) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (alloc_fire && alloc_mask[s] && pick_oh[s][i]) begin
            busy_q[i] <= 1'b1;
            ent_q[i]  <= in_uop[s];
            for (int j = 0; j < ENTRIES; j++) begin
              older_q[j][i] <= busy_q[j] | ahead[s][j];
              older_q[i][j] <= behind[s][j];
            end
          end
        end
      end
    end
  end

  // R1: occupancy never grows without an allocation handshake
  assert_no_stray_alloc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_valid && alloc_ready) |=> ($countones(busy_q) <= $past($countones(busy_q))));

  // R1: allocation lands only on free entries
  genvar s;
  generate
    for (s = 0; s < ALLOC_W; s++) begin : g_slot
      assert_alloc_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_fire && alloc_mask[s]) |-> ((pick_oh[s] & busy_q) == '0 && pick_oh[s] != '0));
    end
  endgenerate

  // R8: flush empties the station
  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (busy_q == '0));
endmodule

// File: tb/rs_sched_test.sv
`timescale 1ns/1ps
module rs_sched_test;
  localparam int AW = 3, NP = 5, OPW = 8, TW = 6, DW = 32, PW = 3, WB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic alloc_valid = 1'b0;
  logic alloc_ready;
  logic [AW-1:0]     alloc_mask = '0;
  logic [AW*OPW-1:0] alloc_op = '0;
  logic [AW*TW-1:0]  alloc_dst = '0;
  logic [AW*PW-1:0]  alloc_port = '0;
  logic [AW*TW-1:0]  alloc_s1_tag = '0;
  logic [AW-1:0]     alloc_s1_rdy = '0;
  logic [AW*DW-1:0]  alloc_s1_data = '0;
  logic [AW*TW-1:0]  alloc_s2_tag = '0;
  logic [AW-1:0]     alloc_s2_rdy = '0;
  logic [AW*DW-1:0]  alloc_s2_data = '0;
  logic [WB-1:0]     wb_valid = '0;
  logic [WB*TW-1:0]  wb_tag = '0;
  logic [WB*DW-1:0]  wb_data = '0;
  logic [NP-1:0]     disp_valid;
  logic [NP-1:0]     disp_ready = '0;
  logic [NP*OPW-1:0] disp_op;
  logic [NP*TW-1:0]  disp_dst;
  logic [NP*DW-1:0]  disp_s1_data;
  logic [NP*DW-1:0]  disp_s2_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  rs_sched uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_mask(alloc_mask),
    .alloc_op(alloc_op), .alloc_dst(alloc_dst), .alloc_port(alloc_port),
    .alloc_s1_tag(alloc_s1_tag), .alloc_s1_rdy(alloc_s1_rdy), .alloc_s1_data(alloc_s1_data),
    .alloc_s2_tag(alloc_s2_tag), .alloc_s2_rdy(alloc_s2_rdy), .alloc_s2_data(alloc_s2_data),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_dst(disp_dst), .disp_s1_data(disp_s1_data), .disp_s2_data(disp_s2_data));

  function automatic logic [31:0] d1_of(input logic [7:0] op);
    return {24'h5A0000, op};
  endfunction
  function automatic logic [31:0] d2_of(input logic [7:0] op);
    return {op, 24'h00C3C3};
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_slot(input int s, input logic [7:0] op, input logic [5:0] dst,
                          input logic [2:0] port, input logic [5:0] t1, input logic r1,
                          input logic [5:0] t2, input logic r2);
    alloc_op[s*OPW +: OPW]     = op;
    alloc_dst[s*TW +: TW]      = dst;
    alloc_port[s*PW +: PW]     = port;
    alloc_s1_tag[s*TW +: TW]   = t1;
    alloc_s1_rdy[s]            = r1;
    alloc_s1_data[s*DW +: DW]  = d1_of(op);
    alloc_s2_tag[s*TW +: TW]   = t2;
    alloc_s2_rdy[s]            = r2;
    alloc_s2_data[s*DW +: DW]  = d2_of(op);
  endtask

  // called at a falling edge; presents the group for one rising edge
  task automatic push(input logic [2:0] mask);
    alloc_mask  = mask;
    alloc_valid = 1'b1;
    @(negedge clk);
    alloc_valid = 1'b0;
    alloc_mask  = '0;
  endtask

  task automatic wb_pulse(input int b, input logic [5:0] tag, input logic [31:0] data);
    wb_valid[b]          = 1'b1;
    wb_tag[b*TW +: TW]   = tag;
    wb_data[b*DW +: DW]  = data;
    @(negedge clk);
    wb_valid = '0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(alloc_ready, 1'b1, "R9 alloc_ready after reset");
    chk(disp_valid, 5'b00000, "R9 disp_valid after reset");
  endtask

  task automatic t_basic();
    disp_ready = '0;
    set_slot(0, 8'h11, 6'd5, 3'd2, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b001);
    chk(disp_valid, 5'b00100, "R5 only port 2 offers");
    chk(disp_op[2*OPW +: OPW], 8'h11, "R2 opcode");
    chk(disp_dst[2*TW +: TW], 6'd5, "R2 destination tag");
    chk(disp_s1_data[2*DW +: DW], d1_of(8'h11), "R2 first operand");
    chk(disp_s2_data[2*DW +: DW], d2_of(8'h11), "R2 second operand");
    @(negedge clk);
    chk(disp_valid[2], 1'b1, "R7 offer held without ready");
    disp_ready[2] = 1'b1;
    @(negedge clk);
    disp_ready = '0;
    chk(disp_valid[2], 1'b0, "R7 entry freed after handshake");
  endtask

  task automatic t_order();
    disp_ready = '0;
    set_slot(0, 8'hA1, 6'd1, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(1, 8'hA2, 6'd2, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(2, 8'hA3, 6'd3, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b111);
    set_slot(0, 8'hB0, 6'd4, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b001);
    chk(disp_op[1*OPW +: OPW], 8'hA1, "R6 oldest offered first");
    disp_ready[1] = 1'b1;
    @(negedge clk);
    chk(disp_op[1*OPW +: OPW], 8'hA2, "R6 slot 1 after slot 0");
    @(negedge clk);
    chk(disp_op[1*OPW +: OPW], 8'hA3, "R6 slot 2 after slot 1");
    @(negedge clk);
    chk(disp_op[1*OPW +: OPW], 8'hB0, "R6 later group last");
    @(negedge clk);
    chk(disp_valid[1], 1'b0, "R5 one op per cycle drains port 1");
    disp_ready = '0;
  endtask

  task automatic t_older_wakes();
    disp_ready = '0;
    set_slot(0, 8'hC0, 6'd7, 3'd3, 6'd20, 1'b0, 6'd0, 1'b1);
    push(3'b001);
    set_slot(0, 8'hD0, 6'd8, 3'd3, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b001);
    chk(disp_op[3*OPW +: OPW], 8'hD0, "R6 younger ready op offered");
    wb_pulse(0, 6'd20, 32'hCAFE0001);
    chk(disp_op[3*OPW +: OPW], 8'hC0, "R6 older op wins once woken");
    chk(disp_s1_data[3*DW +: DW], 32'hCAFE0001, "R4 captured data");
    do_flush();
  endtask

  task automatic t_wakeup();
    disp_ready = '0;
    set_slot(0, 8'hE0, 6'd9, 3'd0, 6'd12, 1'b0, 6'd13, 1'b0);
    push(3'b001);
    chk(disp_valid[0], 1'b0, "R3 no sources ready");
    wb_pulse(0, 6'd14, 32'h0BAD0BAD);
    chk(disp_valid[0], 1'b0, "R4 unmatched tag ignored");
    wb_pulse(0, 6'd12, 32'h12121212);
    chk(disp_valid[0], 1'b0, "R3 one source still waiting");
    wb_pulse(1, 6'd13, 32'h13131313);
    chk(disp_valid[0], 1'b1, "R4 second bus wakes entry");
    chk(disp_s1_data[0 +: DW], 32'h12121212, "R4 bus 0 data");
    chk(disp_s2_data[0 +: DW], 32'h13131313, "R4 bus 1 data");
    do_flush();
  endtask

  task automatic t_bypass();
    disp_ready = '0;
    set_slot(0, 8'hF0, 6'd10, 3'd4, 6'd0, 1'b1, 6'd30, 1'b0);
    wb_valid[1]          = 1'b1;
    wb_tag[1*TW +: TW]   = 6'd30;
    wb_data[1*DW +: DW]  = 32'h30303030;
    push(3'b001);
    wb_valid = '0;
    chk(disp_valid[4], 1'b1, "R4 broadcast at allocation captured");
    chk(disp_s2_data[4*DW +: DW], 32'h30303030, "R4 captured at allocation");
    do_flush();
  endtask

  task automatic t_ports();
    disp_ready = '0;
    set_slot(0, 8'h40, 6'd0, 3'd0, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(1, 8'h41, 6'd1, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(2, 8'h42, 6'd2, 3'd2, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b111);
    set_slot(0, 8'h43, 6'd3, 3'd3, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(1, 8'h44, 6'd4, 3'd4, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b011);
    chk(disp_valid, 5'b11111, "R5 all five ports offer");
    for (int q = 0; q < NP; q++)
      chk(disp_op[q*OPW +: OPW], 8'h40 + q[7:0], "R5 port class routing");
    disp_ready = 5'b11111;
    @(negedge clk);
    disp_ready = '0;
    chk(disp_valid, 5'b00000, "R7 five dispatched in one cycle");
  endtask

  task automatic t_mask();
    disp_ready = '0;
    set_slot(0, 8'h50, 6'd0, 3'd0, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(1, 8'h51, 6'd1, 3'd1, 6'd0, 1'b1, 6'd0, 1'b1);
    set_slot(2, 8'h52, 6'd2, 3'd2, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b101);
    chk(disp_valid, 5'b00101, "R10 masked slot skipped");
    do_flush();
  endtask

  task automatic t_full();
    disp_ready = '0;
    for (int g = 0; g < 5; g++) begin
      for (int s = 0; s < AW; s++)
        set_slot(s, 8'h60, 6'd0, 3'd0, 6'd40, 1'b0, 6'd0, 1'b1);
      push(3'b111);
    end
    chk(alloc_ready, 1'b1, "R1 ready with 5 free");
    set_slot(0, 8'h60, 6'd0, 3'd0, 6'd40, 1'b0, 6'd0, 1'b1);
    set_slot(1, 8'h60, 6'd0, 3'd0, 6'd40, 1'b0, 6'd0, 1'b1);
    set_slot(2, 8'h66, 6'd6, 3'd4, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b111);
    chk(alloc_ready, 1'b0, "R1 stall with 2 free");
    chk(disp_valid[4], 1'b1, "R1 eighteenth op present");
    set_slot(0, 8'h77, 6'd7, 3'd3, 6'd0, 1'b1, 6'd0, 1'b1);
    push(3'b001);
    chk(disp_valid[3], 1'b0, "R1 rejected group not stored");
    disp_ready[4] = 1'b1;
    @(negedge clk);
    disp_ready = '0;
    chk(alloc_ready, 1'b1, "R1 ready again with 3 free");
    do_flush();
    chk(disp_valid, 5'b00000, "R8 nothing offered after flush");
    chk(alloc_ready, 1'b1, "R8 all free after flush");
    wb_pulse(0, 6'd40, 32'h40404040);
    chk(disp_valid, 5'b00000, "R8 broadcast wakes no flushed entry");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_order();
    t_older_wakes();
    t_wakeup();
    t_bypass();
    t_ports();
    t_mask();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule